// File: doc/BRIEF.md
# Shared-Pool Sum-of-Products Logic Block

This block is the combinational core of one cell group in a small programmable-logic emulation. A bus of routed signals enters, and each signal is offered to an AND plane in both its true and its inverted form. Every product term in a shared pool picks any set of those literals through its own mask. Each sum-term output then takes the OR of whichever pool terms its steering mask selects. One term may serve several outputs, so logic common to several outputs is built once.

Configuration sits in on-block registers written through a parallel row port. A write selects either a product-term literal mask or an output steering mask by row number. Steering masks are limited to a fixed number of terms per output. A mask that asks for more is cut down to its lowest-indexed terms, and a per-output error flag reports the cut. From the signal inputs to the sum outputs the path holds no register.

Top module: `pt_logic_block`

## Requirements
- R1: After reset every term mask and every steering mask is empty, so every `sum_out` bit and every `steer_err` bit reads 0.
- R2: Literal bit 2i of a term mask selects input i in true form, and bit 2i+1 selects input i inverted. A product term is the AND of every literal its mask selects.
- R3: A product term whose mask selects no literal is logic 1.
- R4: A product term whose mask selects both polarities of the same input is logic 0 for every input value.
- R5: Output o is the OR of the pool terms selected by steering row o, where bit p selects term p. An output whose steering row is empty reads 0.
- R6: A single product term may be steered to several outputs at once. Each of those outputs follows that term.
- R7: A steering write that selects more than MAX_PT terms keeps only the MAX_PT lowest-indexed selected terms and sets that output's `steer_err` bit.
- R8: A steering write that selects exactly MAX_PT terms keeps all of them and clears that output's `steer_err` bit.
- R9: A write with `cfg_kind`=0 loads term row `cfg_row` from `cfg_data`. A write with `cfg_kind`=1 loads steering row `cfg_row`. The new mask acts from the clock edge that captures the write. A write whose row is at or beyond the row count of the selected kind changes nothing.
- R10: `sum_out` follows a change on `sig_in` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = product-term literal mask, 1 = output steering mask |
| cfg_row | input | 7 | Row number: a term index or an output index |
| cfg_data | input | 86 | Mask data. Term rows use the low 72 bits, steering rows use all 86 |
| sig_in | input | 36 | Routed input signals |
| sum_out | output | 16 | Sum-term outputs |
| steer_err | output | 16 | Per-output flag: the last steering write exceeded the term limit |

## Verification
The bench builds the block at its default sizes: 36 inputs, an 86-term pool, 16 outputs and a limit of 16 terms per output. At these sizes a steering row can request far more terms than the limit, so the cut at exactly the limit and the cut beyond it can both be reached. The 7-bit row field also reaches term rows past 85 and steering rows past 15, which tests that out-of-range writes are dropped. Directed configurations set up empty masks, masks that select both polarities of one input, and terms shared between outputs. Randomly filled term pools and steering masks are then compared against a behavioural sum-of-products model.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
    typedef enum logic {
        CFG_TERM  = 1'b0,
        CFG_STEER = 1'b1
    } cfg_kind_e;
endpackage

// File: rtl/pt_literals.sv
`timescale 1ns/1ps
// Offers every routed input in both polarities: even bit true, odd bit inverted.
module pt_literals #(
    parameter int N_IN = 36,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]  sig,
    output logic [LIT_W-1:0] lit
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = sig[i];
        assign lit[2*i+1] = ~sig[i];
    end
endmodule

// File: rtl/pt_and_array.sv
`timescale 1ns/1ps
// Pool of product terms; an unselected literal contributes a 1.
module pt_and_array #(
    parameter int N_IN = 36,
    parameter int N_PT = 86,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [LIT_W-1:0]             lit,
    input  logic [N_PT-1:0][LIT_W-1:0]   mask,
    output logic [N_PT-1:0]              term
);
    for (genvar p = 0; p < N_PT; p++) begin : g_term
        assign term[p] = &(lit | ~mask[p]);
    end
endmodule

// File: rtl/pt_or_plane.sv
`timescale 1ns/1ps
// Each output ORs the pool terms its steering row selects.
module pt_or_plane #(
    parameter int N_PT  = 86,
    parameter int N_OUT = 16
) (
    input  logic [N_OUT-1:0][N_PT-1:0] steer,
    input  logic [N_PT-1:0]            term,
    output logic [N_OUT-1:0]           sum
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        assign sum[o] = |(steer[o] & term);
    end
endmodule

// File: rtl/pt_steer_trim.sv
`timescale 1ns/1ps
// Keeps the lowest-indexed MAX_PT selected terms of a steering mask.
module pt_steer_trim #(
    parameter int N_PT   = 86,
    parameter int MAX_PT = 16,
    localparam int CNT_W = $clog2(N_PT + 1)
) (
    input  logic [N_PT-1:0] raw,
    output logic [N_PT-1:0] kept,
    output logic            over
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        kept = '0;
        over = 1'b0;
        cnt  = '0;
        for (int p = 0; p < N_PT; p++) begin
            if (raw[p]) begin
                if (cnt < CNT_W'(MAX_PT)) begin
                    kept[p] = 1'b1;
                end else begin
                    over = 1'b1;
                end
                cnt = cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pt_logic_block.sv
`timescale 1ns/1ps
module pt_logic_block #(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_OUT  = 16,
    parameter int MAX_PT = 16,
    localparam int LIT_W = 2 * N_IN,
    localparam int ROW_W = $clog2(N_PT),
    localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int CFG_W = (LIT_W > N_PT) ? LIT_W : N_PT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_kind,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [N_IN-1:0]  sig_in,
    output logic [N_OUT-1:0] sum_out,
    output logic [N_OUT-1:0] steer_err
);
    import pt_pkg::*;

    typedef struct packed {
        logic [N_PT-1:0][LIT_W-1:0] lit;
        logic [N_OUT-1:0][N_PT-1:0] steer;
        logic [N_OUT-1:0]           ovf;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic [N_PT-1:0]  trim_kept;
    logic             trim_over;
    logic [LIT_W-1:0] lit;
    logic [N_PT-1:0]  term;
    logic [OUT_W-1:0] out_row;
    cfg_kind_e        kind;

    assign kind    = cfg_kind_e'(cfg_kind);
    assign out_row = cfg_row[OUT_W-1:0];

    pt_steer_trim #(.N_PT(N_PT), .MAX_PT(MAX_PT)) u_trim (
        .raw  (cfg_data[N_PT-1:0]),
        .kept (trim_kept),
        .over (trim_over)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (kind == CFG_TERM) begin
                if (int'(cfg_row) < N_PT) begin
                    cfg_d.lit[cfg_row] = cfg_data[LIT_W-1:0];
                end
            end else begin
                if (int'(cfg_row) < N_OUT) begin
                    cfg_d.steer[out_row] = trim_kept;
                    cfg_d.ovf[out_row]   = trim_over;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pt_literals #(.N_IN(N_IN)) u_lit (
        .sig (sig_in),
        .lit (lit)
    );

    pt_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .lit  (lit),
        .mask (cfg_q.lit),
        .term (term)
    );

    pt_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
        .steer (cfg_q.steer),
        .term  (term),
        .sum   (sum_out)
    );

    assign steer_err = cfg_q.ovf;

    // Checks on stored configuration and the combinational planes
    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        a_r5_empty_steer_low: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.steer[o] == '0) |-> (sum_out[o] == 1'b0));
        a_r7_steer_capped: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(cfg_q.steer[o]) <= MAX_PT);
        a_r7_flag_means_full: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q.ovf[o] |-> ($countones(cfg_q.steer[o]) == MAX_PT));
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term_chk
        a_r3_blank_term_high: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.lit[p] == '0) |-> term[p]);
    end

    a_r9_term_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_kind && (int'(cfg_row) < N_PT))
        |=> (cfg_q.lit[$past(cfg_row)] == $past(cfg_data[LIT_W-1:0])));
endmodule

// File: tb/sim_pt_logic_block.sv
`timescale 1ns/1ps
module sim_pt_logic_block;
    localparam int N_IN   = 36;
    localparam int N_PT   = 86;
    localparam int N_OUT  = 16;
    localparam int MAX_PT = 16;
    localparam int LIT_W  = 2 * N_IN;
    localparam int ROW_W  = $clog2(N_PT);
    localparam int CFG_W  = (LIT_W > N_PT) ? LIT_W : N_PT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_kind = 1'b0;
    logic [ROW_W-1:0] cfg_row = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic [N_IN-1:0]  sig_in = '0;
    logic [N_OUT-1:0] sum_out;
    logic [N_OUT-1:0] steer_err;

    always #4 clk = ~clk;   // 125 MHz

    pt_logic_block u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_row(cfg_row), .cfg_data(cfg_data), .sig_in(sig_in),
        .sum_out(sum_out), .steer_err(steer_err)
    );

    // Behavioural model state
    bit [LIT_W-1:0] m_lit [N_PT];
    bit [N_PT-1:0]  m_st  [N_OUT];
    bit [N_OUT-1:0] m_err;

    // Scoreboard queues
    bit [N_OUT-1:0] q_out [$];
    bit [N_OUT-1:0] q_err [$];
    string          q_tag [$];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    function automatic bit [N_OUT-1:0] model_eval(bit [N_IN-1:0] v);
        bit [N_PT-1:0]  t;
        bit [N_OUT-1:0] s;
        for (int p = 0; p < N_PT; p++) begin
            t[p] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (m_lit[p][2*i]   && !v[i]) t[p] = 1'b0;
                if (m_lit[p][2*i+1] &&  v[i]) t[p] = 1'b0;
            end
        end
        s = '0;
        for (int o = 0; o < N_OUT; o++)
            for (int p = 0; p < N_PT; p++)
                if (m_st[o][p] && t[p]) s[o] = 1'b1;
        return s;
    endfunction

    task automatic wr(input bit kind, input int row, input bit [CFG_W-1:0] d);
        int c;
        bit [N_PT-1:0] k;
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_kind = kind; cfg_row = row[ROW_W-1:0]; cfg_data = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (!kind && row < N_PT) m_lit[row] = d[LIT_W-1:0];
        if (kind && row < N_OUT) begin
            c = 0; k = '0;
            for (int p = 0; p < N_PT; p++)
                if (d[p]) begin
                    if (c < MAX_PT) k[p] = 1'b1;
                    c++;
                end
            m_st[row]  = k;
            m_err[row] = (c > MAX_PT);
        end
    endtask

    task automatic drive(input bit [N_IN-1:0] v, input string tag);
        @(posedge clk); #1;
        sig_in = v;
        q_out.push_back(model_eval(v));
        q_err.push_back(m_err);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares mid-cycle, after inputs settle and away from the edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_out.size() > 0) begin
                bit [N_OUT-1:0] eo, ee;
                string tg;
                eo = q_out.pop_front();
                ee = q_err.pop_front();
                tg = q_tag.pop_front();
                n_tests++;
                if (sum_out !== eo || steer_err !== ee) begin
                    n_fail++;
                    $display("FAIL %s sum_out=%h exp=%h steer_err=%h exp=%h",
                             tg, sum_out, eo, steer_err, ee);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit [CFG_W-1:0] d;
        for (int p = 0; p < N_PT; p++) m_lit[p] = '0;
        for (int o = 0; o < N_OUT; o++) m_st[o] = '0;
        m_err = '0;
        repeat (3) @(posedge clk);
        drive('0, "R1 reset state");
        @(posedge clk); #1; rst_n = 1'b1;
        drive(36'hFFFFFFFFF, "R1 after reset release");

        // R3: term 0 empty mask, steered to out 0
        wr(1'b1, 0, 86'd1);
        drive(36'h0, "R3 blank term");
        drive(36'h5A5A5A5A5, "R3 blank term");

        // R2: term 1 = in0 & ~in1 (bits 0 and 3), steered to out 1
        wr(1'b0, 1, 86'b1001);
        wr(1'b1, 1, 86'b10);
        drive(36'h1, "R2 literal true/inverted");
        drive(36'h3, "R2 literal true/inverted");
        drive(36'h0, "R2 literal true/inverted");
        drive(36'h2, "R10 combinational follow");
        drive(36'h1, "R10 combinational follow");

        // R4: term 2 selects both polarities of in2
        wr(1'b0, 2, 86'b110000);
        wr(1'b1, 2, 86'b100);
        drive(36'h4, "R4 clash term");
        drive(36'h0, "R4 clash term");

        // R6: term 1 shared by outs 3 and 4
        wr(1'b1, 3, 86'b10);
        wr(1'b1, 4, 86'b10);
        drive(36'h1, "R6 shared term");
        drive(36'h3, "R6 shared term");

        // R7/R8: terms 10..25 clash (zero), term 26 blank (one)
        for (int p = 10; p <= 25; p++) wr(1'b0, p, 86'b11 << (2 * (p % N_IN)));
        d = '0;
        for (int p = 10; p <= 29; p++) d[p] = 1'b1;
        wr(1'b1, 5, d);
        drive(36'h123456789, "R7 overflow cut");
        d = '0;
        for (int p = 11; p <= 26; p++) d[p] = 1'b1;
        wr(1'b1, 6, d);
        drive(36'h987654321, "R8 exactly at limit");

        // R9: out-of-range rows ignored
        wr(1'b0, 100, '1);
        wr(1'b1, 20, '1);
        drive(36'h1, "R9 out-of-range write");
        wr(1'b1, 5, 86'd1);
        drive(36'h0, "R9 steering rewrite");

        // Random pools and steering
        for (int r = 0; r < 12; r++) begin
            for (int p = 0; p < N_PT; p++) begin
                d = '0;
                for (int i = 0; i < LIT_W; i++) d[i] = ($urandom % 20 == 0);
                wr(1'b0, p, d);
            end
            for (int o = 0; o < N_OUT; o++) begin
                d = '0;
                for (int p = 0; p < N_PT; p++) d[p] = ($urandom % ((r % 3 == 0) ? 4 : 9) == 0);
                wr(1'b1, o, d);
            end
            for (int k = 0; k < 10; k++)
                drive({$urandom, $urandom} , "R5 random sum-of-products");
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule